// File: doc/BRIEF.md
# Keyed Register Lock with Interrupt Status and Mask

This block is the word-wide register front end of a one-time-programmable fuse controller. A lock register guards the whole register file. It comes out of reset locked, and only one exact 32-bit key value opens it. While the block is locked, a write to any other address is dropped without any sign that it happened. Writing any value other than the key closes the lock again.

The block also collects six event flags raised by the fuse engine: bus slave error, cache error, read error, read done, program error and program done. Each flag is latched into a status word, and software clears it by writing a one to its bit. An enable mask selects which flags drive the single level interrupt output. Software cannot write the mask directly. It changes only through a set-bits register and a clear-bits register, and both of these read back as zero.

Register map (byte addresses, full 32-bit accesses only, little-endian): lock at 0x00, status at 0x10, mask at 0x14, set-bits at 0x18, clear-bits at 0x1C. Any other address reads zero and ignores writes.

Top module: `fuse_regif_top`

## Requirements
- R1: After reset the lock register reads 1, status reads 0, the mask reads 0x8000001F and `irq` is low.
- R2: A write of exactly 0x0000DF0D to the lock register makes it read 0. A write of any other value makes it read 1.
- R3: While the lock register reads 1, a write to any address other than the lock register changes no register.
- R4: Event input `evt_set[5]` sets status bit 31 and `evt_set[4:0]` set status bits 4..0. All other status and mask bits read zero.
- R5: Writing a one to a status bit in 0x8000001F clears that bit. Written zeros and writes to reserved bits have no effect.
- R6: A direct write to the mask address leaves the mask unchanged.
- R7: A write to the set-bits register ORs the written source bits into the mask. The register reads zero.
- R8: A write to the clear-bits register removes the written source bits from the mask. The register reads zero.
- R9: `irq` is high exactly when status AND mask is nonzero, one clock after that condition changes.
- R10: When an event input and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Reads of unmapped or misaligned addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | 6 | Event pulses from the fuse engine (bit 5 maps to status bit 31) |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit byte address, the five register offsets listed above and the 0x0000DF0D key. With these values every mapped register can be reached, and so can an unmapped word (0x20) and a misaligned one (0x11). Near-miss keys that differ only in the upper half of the word can also be exercised. The mask set/clear arithmetic, the write-one-to-clear against an event in the same cycle, and the one-cycle interrupt latency are all checked while the block is unlocked. The locked path is checked by showing that writes to the mask and status registers are dropped.

// File: rtl/fuse_regif_pkg.sv
package fuse_regif_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NSRC   = 6;
  // status word position of each event source, index = evt_set bit
  localparam int unsigned SRC_BIT [NSRC] = '{0, 1, 2, 3, 4, 31};

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_LOCK = 3'd1,
    SEL_STAT = 3'd2,
    SEL_MASK = 3'd3,
    SEL_MSET = 3'd4,
    SEL_MCLR = 3'd5
  } regsel_e;

  function automatic logic [NSRC-1:0] src_pack(input logic [WORD_W-1:0] w);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = w[SRC_BIT[i]];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] src_unpack(input logic [NSRC-1:0] s);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) r[SRC_BIT[i]] = s[i];
    return r;
  endfunction
endpackage

// File: rtl/fuse_regif_dec.sv
module fuse_regif_dec
  import fuse_regif_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_LOCK = 8'h00,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_MSET = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_MCLR = 8'h1C
) (
  input  logic [ADDR_W-1:0] addr,
  output regsel_e           sel
);
  always_comb begin
    unique case (addr)
      OFS_LOCK: sel = SEL_LOCK;
      OFS_STAT: sel = SEL_STAT;
      OFS_MASK: sel = SEL_MASK;
      OFS_MSET: sel = SEL_MSET;
      OFS_MCLR: sel = SEL_MCLR;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/fuse_regif_lock.sv
module fuse_regif_lock #(
  parameter int unsigned       W   = 32,
  parameter logic [W-1:0]      KEY = 32'h0000_DF0D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         locked
);
  logic lock_d, lock_q;

  always_comb begin
    lock_d = lock_q;
    if (wr_en) lock_d = (wdata == KEY) ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= 1'b1;
    else if (wr_en) lock_q <= lock_d;
  end

  assign locked = lock_q;

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == KEY) |=> !locked);
  // R2
  key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata != KEY) |=> locked);
endmodule

// File: rtl/fuse_regif_irq.sv
module fuse_regif_irq #(
  parameter int unsigned NS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] evt_set,
  input  logic          stat_clr_en,
  input  logic          mask_set_en,
  input  logic          mask_clr_en,
  input  logic [NS-1:0] wbits,
  output logic [NS-1:0] status,
  output logic [NS-1:0] mask,
  output logic          irq
);
  logic [NS-1:0] status_d, status_q, mask_d, mask_q;
  logic          irq_d, irq_q;
  logic          stat_upd, mask_upd;

  assign stat_upd = stat_clr_en | (|evt_set);
  assign mask_upd = mask_set_en | mask_clr_en;

  for (genvar i = 0; i < NS; i++) begin : g_src
    always_comb begin
      status_d[i] = evt_set[i] | (status_q[i] & ~(stat_clr_en & wbits[i]));
      mask_d[i]   = mask_q[i];
      if (mask_set_en && wbits[i])      mask_d[i] = 1'b1;
      else if (mask_clr_en && wbits[i]) mask_d[i] = 1'b0;
    end

    // R10
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[i] |=> status_q[i]);
    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr_en && wbits[i] && !evt_set[i]) |=> !status_q[i]);
  end

  always_comb irq_d = |(status_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      if (stat_upd) status_q <= status_d;
      if (mask_upd) mask_q   <= mask_d;
      irq_q <= irq_d;
    end
  end

  assign status = status_q;
  assign mask   = mask_q;
  assign irq    = irq_q;

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_en |=> ((mask_q & $past(wbits)) == $past(wbits)));
  // R8
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clr_en |=> ((mask_q & $past(wbits)) == '0));
endmodule

// File: rtl/fuse_regif_top.sv
module fuse_regif_top
  import fuse_regif_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [31:0]       KEY      = 32'h0000_DF0D,
  parameter logic [ADDR_W-1:0] OFS_LOCK = 8'h00,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_MSET = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_MCLR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [5:0]        evt_set,
  output logic              irq
);
  localparam logic [WORD_W-1:0] SRC_WORD = src_unpack('1);

  regsel_e         sel;
  logic            locked, wr_open;
  logic [NSRC-1:0] wbits, status_w, mask_w;

  fuse_regif_dec #(
    .ADDR_W(ADDR_W), .OFS_LOCK(OFS_LOCK), .OFS_STAT(OFS_STAT),
    .OFS_MASK(OFS_MASK), .OFS_MSET(OFS_MSET), .OFS_MCLR(OFS_MCLR)
  ) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  fuse_regif_lock #(.W(WORD_W), .KEY(KEY)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_we && sel == SEL_LOCK),
    .wdata  (bus_wdata),
    .locked (locked)
  );

  assign wr_open = bus_we && !locked;
  assign wbits   = src_pack(bus_wdata);

  fuse_regif_irq #(.NS(NSRC)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_set     (evt_set),
    .stat_clr_en (wr_open && sel == SEL_STAT),
    .mask_set_en (wr_open && sel == SEL_MSET),
    .mask_clr_en (wr_open && sel == SEL_MCLR),
    .wbits       (wbits),
    .status      (status_w),
    .mask        (mask_w),
    .irq         (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_LOCK: bus_rdata = {{(WORD_W-1){1'b0}}, locked};
      SEL_STAT: bus_rdata = src_unpack(status_w);
      SEL_MASK: bus_rdata = src_unpack(mask_w);
      default:  bus_rdata = '0;
    endcase
  end

  // R3
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && locked && sel != SEL_LOCK) |=> $stable(mask_w));
  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~SRC_WORD) == '0);
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_w & mask_w)) |=> irq);
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_w & mask_w)) |=> !irq);
endmodule

// File: tb/fuse_regif_top_bench.sv
`timescale 1ns/1ps
module fuse_regif_top_bench;
  logic        clk, rst_n, bus_we, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  evt_set;
  int          n_chk, n_fail;

  fuse_regif_top u_fuse_regif_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0000_0001, 8'd1},  // R1 locked at reset
    '{1'b1, 8'h18, 32'h0000_0000, 8'd3},
    '{1'b1, 8'h1C, 32'hFFFF_FFFF, 8'd3},  // R3 dropped while locked
    '{1'b0, 8'h14, 32'h8000_001F, 8'd3},
    '{1'b1, 8'h00, 32'h0000_1234, 8'd2},
    '{1'b0, 8'h00, 32'h0000_0001, 8'd2},  // R2 wrong key
    '{1'b1, 8'h00, 32'h0000_DF0D, 8'd2},
    '{1'b0, 8'h00, 32'h0000_0000, 8'd2},  // R2 key opens
    '{1'b1, 8'h1C, 32'h0000_000A, 8'd8},
    '{1'b0, 8'h14, 32'h8000_0015, 8'd8},  // R8 clear bits
    '{1'b0, 8'h1C, 32'h0000_0000, 8'd8},
    '{1'b1, 8'h18, 32'h0000_0002, 8'd7},
    '{1'b0, 8'h14, 32'h8000_0017, 8'd7},  // R7 set bits
    '{1'b0, 8'h18, 32'h0000_0000, 8'd7},
    '{1'b1, 8'h14, 32'h0000_0000, 8'd6},
    '{1'b0, 8'h14, 32'h8000_0017, 8'd6},  // R6 mask write ignored
    '{1'b0, 8'h20, 32'h0000_0000, 8'd11}, // R11 unmapped
    '{1'b1, 8'h00, 32'h0001_DF0D, 8'd2},
    '{1'b0, 8'h00, 32'h0000_0001, 8'd2}   // R2 near-miss key relocks
  };

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic done();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; evt_set = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(1, 8'h10, 32'h0);
    rd(1, 8'h14, 32'h8000_001F);
    chk(1, {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else           rd(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
    end

    // events and interrupt latency; mask is 0x80000017 here
    wr(8'h00, 32'h0000_DF0D);
    @(negedge clk) evt_set = 6'b100001;
    @(negedge clk) evt_set = 6'b000000;
    #1 chk(4, bus_rdata & 32'h0, 32'h0);
    bus_addr = 8'h10;
    #1 chk(4, bus_rdata, 32'h8000_0001);   // R4 positions
    chk(9, {31'b0, irq}, 32'h0);           // R9 not yet
    @(negedge clk) chk(9, {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h7FFF_FFE0);              // reserved bits only
    rd(5, 8'h10, 32'h8000_0001);           // R5 no effect
    wr(8'h10, 32'h0000_0001);
    rd(5, 8'h10, 32'h8000_0000);           // R5 clear
    wr(8'h1C, 32'h8000_0000);
    @(negedge clk) chk(9, {31'b0, irq}, 32'h0); // R9 masked off
    rd(11, 8'h11, 32'h0);                  // R11 misaligned

    // R10 event beats same-cycle clear
    @(negedge clk);
    bus_addr = 8'h10; bus_wdata = 32'h0000_0004; bus_we = 1'b1; evt_set = 6'b000100;
    @(negedge clk);
    bus_we = 1'b0; evt_set = '0;
    rd(10, 8'h10, 32'h8000_0004);

    // R3 status clear dropped while locked
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(3, 8'h10, 32'h8000_0004);
    done();
  end
endmodule